// File: doc/BRIEF.md
# Host-Port Breakpoint and Interrupt Router

This block connects an on-chip CPU, a host processor port and ten serial-engine interrupt sources. It holds a 16-bit breakpoint address that only the host can write. It compares that address with the CPU program counter on every cycle. When the two are equal, it sets a sticky debug interrupt toward the CPU. The host clears that interrupt by writing zero to the breakpoint register.

The block also holds a 16-bit routing register. For each interrupt source, the routing register decides whether an enabled interrupt goes to the host (the host interrupt line and the host status word) or stays with the CPU. The two start-of-frame sources are the exception: each has its own explicit CPU-delivery bit. Both registers can be read from the host side and from the CPU side, but only the host side can write them. Reads on either side are combinational, through a select input.

Top module: `hbir_top`

## Requirements
- R1: After a synchronous active-low reset, the breakpoint register reads 0x0000, the routing register reads 0x1400 and `bkpt_irq` is 0.
- R2: A host write (`host_wr_en`=1) stores `host_wdata` at the next clock edge: `host_sel`=0 writes the breakpoint register and `host_sel`=1 writes the routing register. `host_rdata` (selected by `host_sel`) and `cpu_rdata` (selected by `cpu_sel`) show the stored value with the same encoding. The CPU has no write path.
- R3: When `cpu_pc` equals a nonzero breakpoint value, `bkpt_irq` is 1 from the following clock edge and stays 1 after `cpu_pc` moves on.
- R4: A host write of zero to the breakpoint register clears `bkpt_irq` at that edge. If a match happens in the same cycle, the clear wins.
- R5: While the breakpoint register holds zero, no value of `cpu_pc` sets `bkpt_irq`.
- R6: Each source's index in `src_irq`, `src_en`, `host_status` and `cpu_irq`, and its routing bit, are:
  - 0 done1, routing bit 3
  - 1 done2, routing bit 4
  - 2 reset1, routing bit 2
  - 3 reset2, routing bit 9
  - 4 resume1, routing bit 6
  - 5 resume2, routing bit 7
  - 6 sof1, host bit 11 and CPU bit 10
  - 7 sof2, host bit 13 and CPU bit 12
  - 8 id, routing bit 14
  - 9 vbus, routing bit 15

  Bits 8 and 1 are plain storage.
- R7: For a source other than sof1/sof2 that is enabled and active, a routing bit of 1 sets its `host_status` bit and clears its `cpu_irq` bit. A routing bit of 0 does the reverse. `host_intr` is the OR of `host_status`.
- R8: The `cpu_irq` bit of sof1 or sof2 follows that source's CPU bit, independently of its host bit, so the source can reach both destinations at once.
- R9: A source with `src_en`=0 reaches neither `host_status` nor `cpu_irq`.
- R10: Routing bits 5 and 0 always read 0, and writes to them are ignored.
- R11: A nonzero write to the breakpoint register leaves a pending `bkpt_irq` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_sel | input | 1 | Host register select: 0 breakpoint, 1 routing |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_sel` |
| cpu_sel | input | 1 | CPU register select: 0 breakpoint, 1 routing |
| cpu_rdata | output | 16 | CPU read data for `cpu_sel` |
| cpu_pc | input | 16 | CPU program counter |
| bkpt_irq | output | 1 | Sticky breakpoint debug interrupt to the CPU |
| src_irq | input | 10 | Raw interrupt sources, indexed as in R6 |
| src_en | input | 10 | Per-source enables |
| host_status | output | 10 | Enabled sources routed to the host |
| host_intr | output | 1 | Host interrupt line |
| cpu_irq | output | 10 | Enabled sources delivered to the CPU |

## Verification
A routing register holding a wrong bit shows up at once, in the same cycle, as a source appearing on the wrong side of `host_status` versus `cpu_irq`. It also shows up in the read-back value on both read ports. A wrong breakpoint flag shows one clock edge after the cause. That cause is a missed match, a spurious match at address zero, a lost clear, or a clear that loses to a simultaneous match. Because the flag is sticky, the error then stays on `bkpt_irq` until the next zero write.

// File: rtl/hbir_pkg.sv
// Package: shared constants for the breakpoint and interrupt router.
// Assumes ten interrupt sources and a 16-bit routing register.
package hbir_pkg;
    localparam int DATA_W  = 16;
    localparam int N_SRC   = 10;
    localparam int SRC_SOF1 = 6;
    localparam int SRC_SOF2 = 7;

    // Host routing bit for each source index
    localparam int HOST_BIT [N_SRC] = '{3, 4, 2, 9, 6, 7, 11, 13, 14, 15};

    localparam logic [DATA_W-1:0] ROUTE_RESET = 16'h1400;
    localparam logic [DATA_W-1:0] ROUTE_WMASK = 16'hFFDE;

    typedef enum logic {SEL_BKPT = 1'b0, SEL_ROUTE = 1'b1} reg_sel_e;

    // CPU delivery bit for the two start-of-frame sources
    function automatic int sof_cpu_bit(input int idx);
        return (idx == SRC_SOF1) ? 10 : 12;
    endfunction
endpackage

// File: rtl/hbir_bkpt_unit.sv
// Breakpoint unit: holds the host-written breakpoint address and a sticky
// match flag. Assumes the write strobe is already qualified for this register.
module hbir_bkpt_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] addr_q,
    output logic              flag_q
);
    localparam logic [ADDR_W-1:0] ZERO = '0;

    logic clr;
    logic hit;

    // Decode a clearing write and a live match against a nonzero address
    always_comb begin
        clr = wr_en && (wdata == ZERO);
        hit = (addr_q != ZERO) && (pc == addr_q);
    end

    // Breakpoint address register
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= ZERO;
        else if (wr_en)
            addr_q <= wdata;
    end

    // Sticky flag; clear has priority over a same-cycle match
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (clr)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
    end

    // R4
    bkpt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == ZERO) |=> !flag_q);
    // R3
    bkpt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wdata == ZERO) && addr_q != ZERO && pc == addr_q) |=> flag_q);
    // R5
    bkpt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q == ZERO && !flag_q) |=> !flag_q);
    // R11
    bkpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && wr_en && wdata != ZERO) |=> flag_q);
endmodule

// File: rtl/hbir_route_regs.sv
// Routing register: host-writable, with reserved bits forced to zero.
// Assumes the write strobe is already qualified for this register.
module hbir_route_regs
    import hbir_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] route_q
);
    // Store only writable bits; reset to the start-of-frame CPU defaults
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= ROUTE_RESET[W-1:0];
        else if (wr_en)
            route_q <= wdata & ROUTE_WMASK[W-1:0];
    end

    // R1
    route_rst_chk: assert property (@(posedge clk)
        !rst_n |=> route_q == ROUTE_RESET[W-1:0]);
    // R10
    route_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (route_q[5] == 1'b0 && route_q[0] == 1'b0));
endmodule

// File: rtl/hbir_route_mux.sv
// Routing mux: steers each enabled source to the host or the CPU side.
// Start-of-frame sources use separate host and CPU bits. Purely combinational.
module hbir_route_mux
    import hbir_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic [DATA_W-1:0] route,
    input  logic [NS-1:0]     irq,
    input  logic [NS-1:0]     en,
    output logic [NS-1:0]     to_host,
    output logic [NS-1:0]     to_cpu
);
    localparam logic [NS-1:0] SOF_MASK = (NS'(1) << SRC_SOF1) | (NS'(1) << SRC_SOF2);

    for (genvar i = 0; i < NS; i++) begin : g_src
        localparam int HB = HOST_BIT[i];
        logic live;

        // Gate the source by its enable
        always_comb live = irq[i] & en[i];

        if (i == SRC_SOF1 || i == SRC_SOF2) begin : g_sof
            localparam int CB = sof_cpu_bit(i);
            // Independent host and CPU delivery
            always_comb begin
                to_host[i] = live & route[HB];
                to_cpu[i]  = live & route[CB];
            end
        end else begin : g_plain
            // Exclusive delivery selected by one bit
            always_comb begin
                to_host[i] = live & route[HB];
                to_cpu[i]  = live & ~route[HB];
            end
        end
    end

    // R9
    always_comb en_gate_chk: assert (((to_host | to_cpu) & ~en) == '0);
    // R7
    always_comb excl_chk: assert ((to_host & to_cpu & ~SOF_MASK) == '0);
endmodule

// File: rtl/hbir_top.sv
// Top: host-port breakpoint and interrupt router. Host writes the two
// registers; both host and CPU read them through combinational selects.
module hbir_top
    import hbir_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cpu_sel,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [DATA_W-1:0] cpu_pc,
    output logic              bkpt_irq,
    input  logic [N_SRC-1:0]  src_irq,
    input  logic [N_SRC-1:0]  src_en,
    output logic [N_SRC-1:0]  host_status,
    output logic              host_intr,
    output logic [N_SRC-1:0]  cpu_irq
);
    logic              wr_bkpt;
    logic              wr_route;
    logic [DATA_W-1:0] bkpt_q;
    logic [DATA_W-1:0] route_q;

    // Qualify the host write strobe per register
    always_comb begin
        wr_bkpt  = host_wr_en && (reg_sel_e'(host_sel) == SEL_BKPT);
        wr_route = host_wr_en && (reg_sel_e'(host_sel) == SEL_ROUTE);
    end

    hbir_bkpt_unit #(.ADDR_W(DATA_W)) u_bkpt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_bkpt),
        .wdata  (host_wdata),
        .pc     (cpu_pc),
        .addr_q (bkpt_q),
        .flag_q (bkpt_irq)
    );

    hbir_route_regs #(.W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_route),
        .wdata   (host_wdata),
        .route_q (route_q)
    );

    hbir_route_mux #(.NS(N_SRC)) u_mux (
        .route   (route_q),
        .irq     (src_irq),
        .en      (src_en),
        .to_host (host_status),
        .to_cpu  (cpu_irq)
    );

    // Read selects for both sides and the host interrupt line
    always_comb begin
        host_rdata = host_sel ? route_q : bkpt_q;
        cpu_rdata  = cpu_sel  ? route_q : bkpt_q;
        host_intr  = |host_status;
    end

    // R1
    bkpt_rst_chk: assert property (@(posedge clk) !rst_n |=> !bkpt_irq);
endmodule

// File: tb/hbir_top_test.sv
module hbir_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        cpu_sel = 1'b0;
    logic [15:0] cpu_rdata;
    logic [15:0] cpu_pc = '0;
    logic        bkpt_irq;
    logic [9:0]  src_irq = '0;
    logic [9:0]  src_en = '0;
    logic [9:0]  host_status;
    logic        host_intr;
    logic [9:0]  cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    hbir_top uut (.*);

    // {route, irq, en, expected host_status, expected cpu_irq}
    localparam int NV = 8;
    localparam logic [55:0] VECS [NV] = '{
        {16'h1400, 10'h3FF, 10'h3FF, 10'h000, 10'h3FF},
        {16'h0000, 10'h3FF, 10'h3FF, 10'h000, 10'h33F},
        {16'hFFDE, 10'h3FF, 10'h3FF, 10'h3FF, 10'h0C0},
        {16'hFFDE, 10'h3FF, 10'h000, 10'h000, 10'h000},
        {16'h0018, 10'h3FF, 10'h3FF, 10'h003, 10'h33C},
        {16'hC204, 10'h2AA, 10'h3FF, 10'h208, 10'h022},
        {16'h28C0, 10'h3FF, 10'h0F5, 10'h0F0, 10'h005},
        {16'h3400, 10'h0C0, 10'h3FF, 10'h080, 10'h0C0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_sel   = sel;
        host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        host_sel = 1'b0; cpu_sel = 1'b1;
        #1;
        check("R1 bkpt", host_rdata, 16'h0000);
        check("R1 route", cpu_rdata, 16'h1400);
        check("R1 irq", {15'd0, bkpt_irq}, 16'd0);

        // R6 R7 R8 R9 vector walk
        for (int v = 0; v < NV; v++) begin
            host_write(1'b1, VECS[v][55:40]);
            src_irq = VECS[v][39:30];
            src_en  = VECS[v][29:20];
            #1;
            check("R2 route readback", host_rdata, VECS[v][55:40]);
            check("R7 host_status", {6'd0, host_status}, {6'd0, VECS[v][19:10]});
            check("R8 cpu_irq", {6'd0, cpu_irq}, {6'd0, VECS[v][9:0]});
            check("R7 host_intr", {15'd0, host_intr}, {15'd0, |VECS[v][19:10]});
        end

        // R10 reserved bits
        host_write(1'b1, 16'hFFFF);
        host_sel = 1'b1; #1;
        check("R10 all ones", host_rdata, 16'hFFDE);
        host_write(1'b1, 16'h0021);
        host_sel = 1'b1; #1;
        check("R10 reserved only", host_rdata, 16'h0000);

        // R5 zero address never matches
        cpu_pc = 16'h0000;
        repeat (3) @(negedge clk);
        check("R5 zero addr", {15'd0, bkpt_irq}, 16'd0);

        // R3 match sets sticky flag
        host_write(1'b0, 16'h1234);
        cpu_sel = 1'b0; #1;
        check("R2 cpu read bkpt", cpu_rdata, 16'h1234);
        check("R3 no early match", {15'd0, bkpt_irq}, 16'd0);
        cpu_pc = 16'h1234;
        @(negedge clk);
        check("R3 set", {15'd0, bkpt_irq}, 16'd1);
        cpu_pc = 16'h0100;
        repeat (2) @(negedge clk);
        check("R3 sticky", {15'd0, bkpt_irq}, 16'd1);

        // R11 nonzero write keeps flag
        host_write(1'b0, 16'h5678);
        check("R11 hold", {15'd0, bkpt_irq}, 16'd1);

        // R4 clear wins over simultaneous match
        @(negedge clk);
        cpu_pc     = 16'h5678;
        host_wr_en = 1'b1;
        host_sel   = 1'b0;
        host_wdata = 16'h0000;
        @(negedge clk);
        host_wr_en = 1'b0;
        check("R4 clear wins", {15'd0, bkpt_irq}, 16'd0);
        cpu_pc = 16'h0000;
        repeat (2) @(negedge clk);
        check("R5 after clear", {15'd0, bkpt_irq}, 16'd0);

        // R4 plain clear after a match
        host_write(1'b0, 16'h0042);
        cpu_pc = 16'h0042;
        @(negedge clk);
        cpu_pc = 16'h0000;
        check("R3 second set", {15'd0, bkpt_irq}, 16'd1);
        host_write(1'b0, 16'h0000);
        check("R4 clear", {15'd0, bkpt_irq}, 16'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule